// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block sits beside the fetch stage and, every cycle, turns the current fetch address into the address to fetch next. A small direct-mapped table holds, for each entry, a valid bit, an address tag, a stored branch target and a two-bit saturating direction counter. When the fetch address matches an entry whose counter leans taken, fetch jumps straight to the stored target with no penalty cycle. When the address matches but the counter leans not-taken, fetch continues sequentially. When nothing matches, a static rule decides from the branch offset delivered by fetch predecode: a branch that jumps backward is taken and one that jumps forward is not.

The stage that resolves branches reports each branch outcome to the block with the actual direction, the actual target and the next address that fetch actually used after that branch. The block trains its table from these reports and, when the reported next address disagrees with the true one, raises a redirect with the correct address and drives a flush mask so that the younger, wrongly fetched stages have their control values cleared. In that same cycle the redirect address replaces the prediction on the next-address output.

Top module: `branch_target_predictor`

## Requirements
- R1: After synchronous active-low reset every table entry is invalid, so every fetch address misses (`pred_hit` = 0).
- R2: A fetch address whose index bits and tag bits match a valid entry with counter value 2 or 3 gives `pred_hit` = 1, `pred_taken` = 1 and `pred_next_pc` equal to the stored target.
- R3: A matching entry with counter value 0 or 1 gives `pred_hit` = 1, `pred_taken` = 0 and `pred_next_pc` = fetch address + 4.
- R4: Each resolution that matches an entry moves its counter up by one when taken and down by one when not taken, saturating at 3 and 0; starting from a strong state the predicted direction changes only after two opposite outcomes in a row.
- R5: On a miss, when `fetch_is_branch` = 1 and the two's-complement word offset is negative (bit 15 set), the prediction is taken with `pred_next_pc` = fetch address + 4 + offset × 4; otherwise it is not taken with `pred_next_pc` = fetch address + 4.
- R6: A resolution that misses the table allocates the entry only when taken, storing the tag, the actual target and counter value 2 (weakly taken); a not-taken miss leaves the table unchanged.
- R7: A taken resolution that matches an entry overwrites its stored target with the reported target.
- R8: When `res_valid` = 1 and the true next address (the target if taken, else resolved address + 4) differs from `res_pred_next_pc`, in the same cycle `redirect_valid` = 1, `redirect_pc` = the true next address, every bit of `flush_vec` = 1 and `pred_next_pc` = `redirect_pc`; otherwise `redirect_valid` = 0 and `flush_vec` = 0.
- R9: A resolution and a lookup to the same entry in one cycle leave the lookup reading the contents from before that update.
- R10: The index is address bits [5:2] and the tag is bits [31:6]; two addresses that share an index but differ in the tag do not match each other, and a taken resolution of one replaces the other's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| fetch_is_branch | input | 1 | Predecode: the fetched word is a conditional branch |
| fetch_offset | input | 16 | Predecode: signed word offset of that branch |
| pred_next_pc | output | 32 | Address to fetch next cycle (redirect wins) |
| pred_taken | output | 1 | Predicted direction for the fetched word |
| pred_hit | output | 1 | Fetch address matched a valid table entry |
| res_valid | input | 1 | A branch resolution is reported this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual direction of the resolved branch |
| res_target | input | 32 | Actual taken target of the resolved branch |
| res_pred_next_pc | input | 32 | Next address fetch used after that branch |
| redirect_valid | output | 1 | Misprediction detected; restart fetch |
| redirect_pc | output | 32 | Correct address to restart fetch at |
| flush_vec | output | 3 | One bit per younger stage whose control is cleared |

## Verification
A corrupted counter shows at the ports on the very next lookup of its address, as a direction and next address that differ from the count of outcomes reported since allocation; the bench walks one entry through every counter value and both saturation limits, checking each step. A wrong tag, valid bit or target appears as a wrong hit flag or next address on the first lookup after the faulty write, and the bench looks up every index after reset and after allocation, plus aliased addresses. A wrong update ordering is exposed in the cycle where a resolution and a lookup share an entry, and a wrong mismatch rule shows directly on the redirect and flush outputs in the reporting cycle.

// File: rtl/bp_pkg.sv
// Package: shared types and the saturating counter step for the predictor.
// Assumes counters are two bits wide; values 2 and 3 mean "taken".
package bp_pkg;

    typedef logic [1:0] sat2_t;

    localparam sat2_t SAT2_WEAK_TAKEN = 2'b10;
    localparam sat2_t SAT2_MAX        = 2'b11;
    localparam sat2_t SAT2_MIN        = 2'b00;

    // Move a counter one step toward the reported outcome, clamped at the ends.
    function automatic sat2_t sat2_step(input sat2_t cur, input logic taken);
        if (taken) begin
            return (cur == SAT2_MAX) ? cur : cur + 2'b01;
        end
        return (cur == SAT2_MIN) ? cur : cur - 2'b01;
    endfunction

endpackage

// File: rtl/bp_target_table.sv
// Direct-mapped table of valid, tag, target and direction counter.
// Lookup is combinational from the registers, so an update in the same
// cycle is seen by lookups only from the next cycle on.
// Assumes word-aligned addresses: bits [1:0] are ignored.
module bp_target_table
    import bp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    output sat2_t           lk_ctr,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_target
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = PC_W - IDX_W - 2;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PC_W-1:0]    tgt_q [ENTRIES];
    sat2_t              ctr_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             up_hit;
    logic             unused_low_bits;

    // Split both addresses into index and tag fields.
    assign lk_idx = lk_pc[IDX_W+1:2];
    assign lk_tag = lk_pc[PC_W-1:IDX_W+2];
    assign up_idx = up_pc[IDX_W+1:2];
    assign up_tag = up_pc[PC_W-1:IDX_W+2];
    assign unused_low_bits = ^{lk_pc[1:0], up_pc[1:0]};

    // Read port for fetch.
    assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_target = tgt_q[lk_idx];
    assign lk_ctr    = ctr_q[lk_idx];

    // Match test for the resolution write port.
    assign up_hit = valid_q[up_idx] && (tag_q[up_idx] == up_tag);

    // Train a matching entry, or allocate on a taken miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                valid_q[e] <= 1'b0;
                tag_q[e]   <= '0;
                tgt_q[e]   <= '0;
                ctr_q[e]   <= SAT2_MIN;
            end
        end else if (up_valid) begin
            if (up_hit) begin
                ctr_q[up_idx] <= sat2_step(ctr_q[up_idx], up_taken);
                if (up_taken) begin
                    tgt_q[up_idx] <= up_target;
                end
            end else if (up_taken) begin
                valid_q[up_idx] <= 1'b1;
                tag_q[up_idx]   <= up_tag;
                tgt_q[up_idx]   <= up_target;
                ctr_q[up_idx]   <= SAT2_WEAK_TAKEN;
            end
        end
    end

    // R4
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit && up_taken && ctr_q[up_idx] == SAT2_MAX)
        |=> ctr_q[$past(up_idx)] == SAT2_MAX);

    // R4
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit && !up_taken && ctr_q[up_idx] == SAT2_MIN)
        |=> ctr_q[$past(up_idx)] == SAT2_MIN);

    // R6
    alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_hit && up_taken)
        |=> valid_q[$past(up_idx)] && ctr_q[$past(up_idx)] == SAT2_WEAK_TAKEN
            && tgt_q[$past(up_idx)] == $past(up_target));

    // R6
    no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_hit && !up_taken) |=> $stable(valid_q));

endmodule

// File: rtl/bp_static_rule.sv
// Fallback direction rule for fetch addresses that miss the table:
// a predecoded branch with a negative word offset is taken, all else not.
// Assumes the offset counts words relative to the following address.
module bp_static_rule #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic             [PC_W-1:0]  pc,
    input  logic                         is_branch,
    input  logic             [OFF_W-1:0] offset,
    output logic                         st_taken,
    output logic             [PC_W-1:0]  st_target,
    output logic             [PC_W-1:0]  seq_pc
);
    logic [PC_W-1:0] off_ext;

    // Sign-extend the word offset to address width.
    assign off_ext = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};

    // Sequential and branch-target addresses.
    assign seq_pc    = pc + PC_W'(4);
    assign st_target = seq_pc + (off_ext << 2);

    // Backward branches go, forward ones fall through.
    assign st_taken  = is_branch & offset[OFF_W-1];

endmodule

// File: rtl/bp_resolve_check.sv
// Compares the true next address of a resolved branch with the one fetch
// used, and raises the redirect and the flush mask in the same cycle.
// Assumes the resolving stage reports each branch once.
module bp_resolve_check #(
    parameter int PC_W    = 32,
    parameter int FLUSH_W = 3
) (
    input  logic               res_valid,
    input  logic [PC_W-1:0]    res_pc,
    input  logic               res_taken,
    input  logic [PC_W-1:0]    res_target,
    input  logic [PC_W-1:0]    res_pred_next_pc,
    output logic               mispredict,
    output logic [PC_W-1:0]    correct_pc,
    output logic [FLUSH_W-1:0] flush_vec
);
    // True successor of the resolved branch.
    assign correct_pc = res_taken ? res_target : res_pc + PC_W'(4);

    // A different successor than the one fetched means a wrong path.
    assign mispredict = res_valid && (correct_pc != res_pred_next_pc);

    // Clear control in every younger stage on a wrong path.
    assign flush_vec  = {FLUSH_W{mispredict}};

endmodule

// File: rtl/branch_target_predictor.sv
// Top of the fetch-side predictor: table lookup, static fallback,
// misprediction redirect and flush. All outputs are combinational from
// the inputs and the table registers; training takes effect next cycle.
module branch_target_predictor
    import bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int OFF_W   = 16,
    parameter int FLUSH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PC_W-1:0]    fetch_pc,
    input  logic               fetch_is_branch,
    input  logic [OFF_W-1:0]   fetch_offset,
    output logic [PC_W-1:0]    pred_next_pc,
    output logic               pred_taken,
    output logic               pred_hit,
    input  logic               res_valid,
    input  logic [PC_W-1:0]    res_pc,
    input  logic               res_taken,
    input  logic [PC_W-1:0]    res_target,
    input  logic [PC_W-1:0]    res_pred_next_pc,
    output logic               redirect_valid,
    output logic [PC_W-1:0]    redirect_pc,
    output logic [FLUSH_W-1:0] flush_vec
);
    logic            lk_hit;
    logic [PC_W-1:0] lk_target;
    sat2_t           lk_ctr;
    logic            st_taken;
    logic [PC_W-1:0] st_target, seq_pc;
    logic            mispredict;
    logic [PC_W-1:0] correct_pc;
    logic [PC_W-1:0] guess_pc;

    bp_target_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (fetch_pc),
        .lk_hit    (lk_hit),
        .lk_target (lk_target),
        .lk_ctr    (lk_ctr),
        .up_valid  (res_valid),
        .up_pc     (res_pc),
        .up_taken  (res_taken),
        .up_target (res_target)
    );

    bp_static_rule #(.PC_W(PC_W), .OFF_W(OFF_W)) u_static (
        .pc        (fetch_pc),
        .is_branch (fetch_is_branch),
        .offset    (fetch_offset),
        .st_taken  (st_taken),
        .st_target (st_target),
        .seq_pc    (seq_pc)
    );

    bp_resolve_check #(.PC_W(PC_W), .FLUSH_W(FLUSH_W)) u_resolve (
        .res_valid        (res_valid),
        .res_pc           (res_pc),
        .res_taken        (res_taken),
        .res_target       (res_target),
        .res_pred_next_pc (res_pred_next_pc),
        .mispredict       (mispredict),
        .correct_pc       (correct_pc),
        .flush_vec        (flush_vec)
    );

    // Direction: the counter on a hit, the static rule on a miss.
    always_comb begin
        pred_hit   = lk_hit;
        pred_taken = lk_hit ? lk_ctr[1] : st_taken;
        if (lk_hit) begin
            guess_pc = lk_ctr[1] ? lk_target : seq_pc;
        end else begin
            guess_pc = st_taken ? st_target : seq_pc;
        end
    end

    // A redirect overrides the guess for the next fetch.
    assign redirect_valid = mispredict;
    assign redirect_pc    = correct_pc;
    assign pred_next_pc   = mispredict ? correct_pc : guess_pc;

    // R8
    redirect_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (pred_next_pc == redirect_pc) && (&flush_vec));

    // R2
    hit_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && lk_hit && lk_ctr[1]) |-> pred_next_pc == lk_target);

    // R5
    static_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && !lk_hit && !(fetch_is_branch && fetch_offset[OFF_W-1]))
        |-> pred_next_pc == fetch_pc + PC_W'(4));

endmodule

// File: tb/tb_branch_target_predictor.sv
module tb_branch_target_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int ENT = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_pc;
    logic        fetch_is_branch;
    logic [15:0] fetch_offset;
    logic [31:0] pred_next_pc;
    logic        pred_taken, pred_hit;
    logic        res_valid, res_taken;
    logic [31:0] res_pc, res_target, res_pred_next_pc;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic [2:0]  flush_vec;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference table built from the requirements.
    logic        mv   [ENT];
    logic [25:0] mtag [ENT];
    logic [31:0] mtgt [ENT];
    logic [1:0]  mctr [ENT];

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_target_predictor dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_pc(fetch_pc), .fetch_is_branch(fetch_is_branch), .fetch_offset(fetch_offset),
        .pred_next_pc(pred_next_pc), .pred_taken(pred_taken), .pred_hit(pred_hit),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_pred_next_pc(res_pred_next_pc),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .flush_vec(flush_vec)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check the combinational outputs,
    // then let the edge train both the design and the reference.
    task automatic cyc(input logic [31:0] pc, input logic isb, input logic [15:0] off,
                       input logic rv, input logic [31:0] rpc, input logic rt,
                       input logic [31:0] rtg, input logic [31:0] rpn, input string rq);
        logic [3:0]  ix;
        logic        ehit, etk, emis, uhit;
        logic [31:0] enext, actual;
        @(negedge clk);
        fetch_pc = pc; fetch_is_branch = isb; fetch_offset = off;
        res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtg; res_pred_next_pc = rpn;
        #1;
        ix   = pc[5:2];
        ehit = mv[ix] && (mtag[ix] == pc[31:6]);
        if (ehit) begin
            etk   = mctr[ix][1];
            enext = etk ? mtgt[ix] : pc + 32'd4;
        end else begin
            etk   = isb && off[15];
            enext = etk ? pc + 32'd4 + ({{16{off[15]}}, off} << 2) : pc + 32'd4;
        end
        actual = rt ? rtg : rpc + 32'd4;
        emis   = rv && (actual != rpn);
        if (emis) enext = actual;
        chk(pred_hit == ehit, rq, "pred_hit", {31'd0, pred_hit}, {31'd0, ehit});
        chk(pred_taken == etk, rq, "pred_taken", {31'd0, pred_taken}, {31'd0, etk});
        chk(pred_next_pc == enext, rq, "pred_next_pc", pred_next_pc, enext);
        chk(redirect_valid == emis, rq, "redirect_valid", {31'd0, redirect_valid}, {31'd0, emis});
        chk(flush_vec == (emis ? 3'b111 : 3'b000), rq, "flush_vec",
            {29'd0, flush_vec}, emis ? 32'd7 : 32'd0);
        if (emis) chk(redirect_pc == actual, rq, "redirect_pc", redirect_pc, actual);
        @(posedge clk);
        if (rv) begin
            ix   = rpc[5:2];
            uhit = mv[ix] && (mtag[ix] == rpc[31:6]);
            if (uhit) begin
                if (rt) begin
                    mctr[ix] = (mctr[ix] == 2'd3) ? 2'd3 : mctr[ix] + 2'd1;
                    mtgt[ix] = rtg;
                end else begin
                    mctr[ix] = (mctr[ix] == 2'd0) ? 2'd0 : mctr[ix] - 2'd1;
                end
            end else if (rt) begin
                mv[ix] = 1'b1; mtag[ix] = rpc[31:6]; mtgt[ix] = rtg; mctr[ix] = 2'd2;
            end
        end
    endtask

    task automatic look(input logic [31:0] pc, input string rq);
        cyc(pc, 1'b0, 16'd0, 1'b0, 32'd0, 1'b0, 32'd0, 32'd0, rq);
    endtask

    // Resolution reported with the correct successor (no redirect).
    task automatic train(input logic [31:0] lpc, input logic [31:0] rpc, input logic rt,
                         input logic [31:0] rtg, input string rq);
        cyc(lpc, 1'b0, 16'd0, 1'b1, rpc, rt, rtg, rt ? rtg : rpc + 32'd4, rq);
    endtask

    localparam logic [31:0] BASE  = 32'h0000_1000;
    localparam logic [31:0] ALIAS = 32'h0001_0000;

    initial begin
        for (int e = 0; e < ENT; e++) begin
            mv[e] = 1'b0; mtag[e] = '0; mtgt[e] = '0; mctr[e] = 2'd0;
        end
        rst_n = 1'b0; fetch_pc = '0; fetch_is_branch = 1'b0; fetch_offset = '0;
        res_valid = 1'b0; res_pc = '0; res_taken = 1'b0; res_target = '0; res_pred_next_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: every index misses after reset (R10 index field swept).
        for (int i = 0; i < ENT; i++) look(BASE + 32'(i) * 4, "R1");

        // R5: static rule over offsets on both sides of zero.
        for (int o = -6; o <= 6; o++)
            cyc(BASE + 32'h40, 1'b1, 16'(o), 1'b0, 32'd0, 1'b0, 32'd0, 32'd0, "R5");
        cyc(BASE + 32'h80, 1'b0, 16'hFFF0, 1'b0, 32'd0, 1'b0, 32'd0, 32'd0, "R5");

        // R9 then R6/R2: allocate each index while looking it up, then hit.
        for (int i = 0; i < ENT; i++) begin
            train(BASE + 32'(i) * 4, BASE + 32'(i) * 4, 1'b1, 32'h8000 + 32'(i) * 64, "R9");
            look(BASE + 32'(i) * 4, "R2");
        end

        // R6/R10: not-taken miss at an alias allocates nothing.
        train(ALIAS + 32'd12, ALIAS + 32'd12, 1'b0, 32'd0, "R6");
        look(ALIAS + 32'd12, "R10");
        look(BASE + 32'd12, "R6");

        // R4/R3: walk one counter through every value and both limits.
        begin
            logic pat [14] = '{0,1,1,1,1,0,0,0,0,0,1,1,0,1};
            for (int k = 0; k < 14; k++)
                train(BASE + 32'd20, BASE + 32'd20, pat[k], 32'h9000, pat[k] ? "R4" : "R3");
        end
        look(BASE + 32'd20, "R4");

        // R7: taken hit rewrites the target.
        train(BASE + 32'd28, BASE + 32'd28, 1'b1, 32'h0000_A5A0, "R7");
        look(BASE + 32'd28, "R7");

        // R10: taken alias replaces the entry; the old address now misses.
        train(BASE + 32'd28, ALIAS + 32'd28, 1'b1, 32'h0000_B000, "R10");
        look(ALIAS + 32'd28, "R10");
        look(BASE + 32'd28, "R10");

        // R8: wrong successor in both directions, then a correct one.
        cyc(BASE + 32'd32, 1'b1, 16'hFFFC, 1'b1, BASE + 32'h200, 1'b1, 32'h0000_C000,
            BASE + 32'h204, "R8");
        cyc(BASE + 32'd36, 1'b0, 16'd0, 1'b1, BASE + 32'h200, 1'b0, 32'h0000_C000,
            32'h0000_C000, "R8");
        cyc(BASE + 32'd40, 1'b1, 16'h0004, 1'b1, BASE + 32'h300, 1'b1, 32'h0000_D000,
            32'h0000_D000, "R8");
        look(BASE + 32'h200, "R8");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule